// File: doc/BRIEF.md
# Serial Configuration Write Slave

This block is the receive side of a two-wire configuration port. It watches a clock line and a data line from a bus master, finds start and stop conditions, checks the device address and takes in one fixed write frame. The frame is the address, then two header bytes that are acknowledged and thrown away, then eight configuration bytes. Each configuration byte lands in its own register and shows at once on a parallel output bus. The port is write-only. Using it is optional, because every register comes out of reset holding a working value.

The block also captures five frequency-strap pins while reset is held. After reset it produces a 5-bit frequency code. A mode bit in configuration byte 0 picks the source of that code: the captured straps, or select bits written by software. Two more decoded flags come out of the registers. One asks for all clock outputs to go high impedance. The other picks 48 MHz instead of 24 MHz for the dual-rate output.

Both bus lines are brought into the system clock through a two-flop synchronizer. Bits are taken on the synchronized rising edge of the bus clock. The acknowledge is given by raising `sda_oe`, which the pad logic turns into a low on the data line.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset the eight configuration bytes hold byte0=0x04, byte1=0x0F, byte2=0xFF, byte3=0x3F, byte4=0x00, byte5=0x33, byte6=0x00 and byte7=0x00. Byte k sits on `cfg_bytes[8k+7:8k]`.
- R2: Only the address byte 0xD2 (sent MSB first, with bit 0 = 0 for write) is acknowledged. A frame with any other address gets no acknowledge for any of its bytes and changes no register.
- R3: In a frame with a matching address, the second byte and the third byte are acknowledged and discarded, whatever their value.
- R4: Data bytes 0 to 7 follow the header in that order. Each is shifted in MSB first and written to its register at the acknowledge clock of that byte. A write changes one byte at a time.
- R5: To acknowledge, the slave raises `sda_oe` after the SCL falling edge that ends the 8th bit, and lowers it after the SCL falling edge that ends the 9th clock. `sda_oe` stays low during data bits.
- R6: A repeated start or a stop inside a frame aborts it. Bytes already committed stay, and a partly shifted byte is dropped.
- R7: Bytes sent after the eighth data byte are not acknowledged and have no effect.
- R8: `strap_fs` is captured while `rst` is high. Changes on it after reset have no effect.
- R9: When byte0 bit3 is 0, `freq_sel` equals the captured straps. When it is 1, `freq_sel[4:0]` = {byte0[2], byte0[1], byte0[6], byte0[5], byte0[4]}.
- R10: `sw_mode` = byte0 bit3, `outputs_hiz` = byte0 bit0, and `dual_rate_48` = byte3 bit6.
- R11: A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. SDA changes while SCL is low are data, and a repeated start begins a new frame at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen at the pad, asynchronous |
| strap_fs | input | 5 | Frequency strap pins, FS4..FS0 |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| cfg_bytes | output | 64 | Configuration bytes, byte k at bits 8k+7:8k |
| freq_sel | output | 5 | Effective frequency code, FS4..FS0 |
| sw_mode | output | 1 | 1 = frequency code from software bits |
| outputs_hiz | output | 1 | Request to place all clock outputs in high impedance |
| dual_rate_48 | output | 1 | 1 = dual-rate output at 48 MHz, 0 = 24 MHz |

## Verification
Writing byte 0 changes the source of `freq_sel` and the software code in the same cycle. The bench writes a byte 0 that sets the mode bit and carries a code different from the straps. The cycle model then requires `freq_sel` to jump straight from the strap value to the new code, with no step in between. The second case is an abort that follows a commit within the same frame. Two data bytes are acknowledged, then a repeated start cuts into a half-shifted third byte. The model expects the first two bytes to hold and the third register to keep its old value.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int FS_W = 5;
  localparam logic [BYTE_W-1:0] DEV_ADDR = 8'hD2;
  localparam int HDR_BYTES = 3;  // address + two discarded header bytes

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_ACKWAIT,
    ST_ACK,
    ST_ACKEND,
    ST_IGNORE
  } rx_state_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      0: reg_default = 8'h04;
      1: reg_default = 8'h0F;
      2: reg_default = 8'hFF;
      3: reg_default = 8'h3F;
      5: reg_default = 8'h33;
      default: reg_default = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_bit
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_bit  = sda_s;
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_slave_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_ev,
  input  logic                      stop_ev,
  input  logic                      sda_bit,
  output logic                      sda_oe,
  output logic                      wr_en,
  output logic [$clog2(NBYTES)-1:0] wr_idx,
  output logic [BYTE_W-1:0]         wr_data
);
  localparam int AW    = $clog2(NBYTES);
  localparam int IDXW  = $clog2(NBYTES + HDR_BYTES + 1);
  localparam int LAST  = NBYTES + HDR_BYTES - 1;
  localparam int BCW   = $clog2(BYTE_W);

  rx_state_t         state;
  logic [BYTE_W-1:0] shreg;
  logic [BCW-1:0]    bitcnt;
  logic [IDXW-1:0]   byte_idx;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {shreg[BYTE_W-2:0], sda_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state    <= ST_BITS;
        bitcnt   <= '0;
        byte_idx <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_BITS: if (scl_rise) begin
            shreg  <= shifted;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BCW'(BYTE_W - 1)) state <= ST_ACKWAIT;
          end
          ST_ACKWAIT: if (scl_fall) begin
            if (byte_idx != '0 || shreg == DEV_ADDR) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ACK: if (scl_rise) begin
            if (byte_idx >= IDXW'(HDR_BYTES)) begin
              wr_en   <= 1'b1;
              wr_idx  <= AW'(byte_idx - IDXW'(HDR_BYTES));
              wr_data <= shreg;
            end
            state <= ST_ACKEND;
          end
          ST_ACKEND: if (scl_fall) begin
            sda_oe <= 1'b0;
            if (byte_idx == IDXW'(LAST)) begin
              state <= ST_IGNORE;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              bitcnt   <= '0;
              state    <= ST_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_slave_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(NBYTES)-1:0]  wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NBYTES*BYTE_W-1:0]   regs_flat
);
  localparam int AW = $clog2(NBYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= reg_default(g);
      else if (wr_en && wr_idx == AW'(g)) q <= wr_data;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_slave_pkg::*;
#(
  parameter int NBYTES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_in,
  input  logic                     sda_in,
  input  logic [4:0]               strap_fs,
  output logic                     sda_oe,
  output logic [NBYTES*8-1:0]      cfg_bytes,
  output logic [4:0]               freq_sel,
  output logic                     sw_mode,
  output logic                     outputs_hiz,
  output logic                     dual_rate_48
);
  localparam int AW = $clog2(NBYTES);

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_bit;
  logic wr_en;
  logic [AW-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [FS_W-1:0] strap_q;
  logic [BYTE_W-1:0] ctl0, ctl3;

  cfg_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit)
  );

  cfg_frame_rx #(.NBYTES(NBYTES)) i_rx (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_regfile #(.NBYTES(NBYTES)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(cfg_bytes)
  );

  // straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_fs;
  end

  assign ctl0         = cfg_bytes[0*BYTE_W +: BYTE_W];
  assign ctl3         = cfg_bytes[3*BYTE_W +: BYTE_W];
  assign sw_mode      = ctl0[3];
  assign outputs_hiz  = ctl0[0];
  assign dual_rate_48 = ctl3[6];
  assign freq_sel     = sw_mode ? {ctl0[2], ctl0[1], ctl0[6], ctl0[5], ctl0[4]}
                                : strap_q;
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int NBYTES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_in,
  input logic                sda_oe,
  input logic [NBYTES*8-1:0] cfg_bytes,
  input logic [4:0]          freq_sel,
  input logic                sw_mode
);
  logic pv;
  logic [NBYTES*8-1:0] prev_bytes;
  logic [NBYTES-1:0] chg;

  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
    prev_bytes <= cfg_bytes;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_chg
    assign chg[g] = prev_bytes[g*8 +: 8] != cfg_bytes[g*8 +: 8];
  end

  // R5
  ack_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $rose(sda_oe)) |-> !$past(scl_in));
  // R5
  ack_fall_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $fell(sda_oe)) |-> !$past(scl_in));
  // R4
  commit_in_ack_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && !$stable(cfg_bytes)) |-> (scl_in && sda_oe));
  // R4
  one_byte_per_commit_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> ($countones(chg) <= 1));
  // R8
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && !sw_mode && !$past(sw_mode)) |-> $stable(freq_sel));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NBYTES(NBYTES)) i_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .cfg_bytes(cfg_bytes), .freq_sel(freq_sel), .sw_mode(sw_mode)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bscl = 1'b1, bsda = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic sda_oe, sw_mode, outputs_hiz, dual_rate_48;
  logic [63:0] cfg_bytes;
  logic [4:0] freq_sel;
  logic sda_line;

  int checks = 0, fails = 0, quiet = 0;
  logic pscl = 1'b1, psda = 1'b1;
  logic [7:0] exp_b [8];
  logic [4:0] exp_strap;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz
  assign sda_line = bsda & ~sda_oe;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst(rst), .scl_in(bscl), .sda_in(sda_line),
    .strap_fs(strap), .sda_oe(sda_oe), .cfg_bytes(cfg_bytes),
    .freq_sel(freq_sel), .sw_mode(sw_mode), .outputs_hiz(outputs_hiz),
    .dual_rate_48(dual_rate_48)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = exp_b[k];
    return v;
  endfunction

  function automatic logic [4:0] exp_freq();
    if (exp_b[0][3]) return {exp_b[0][2], exp_b[0][1], exp_b[0][6], exp_b[0][5], exp_b[0][4]};
    return exp_strap;
  endfunction

  // bus activity tracker
  always @(posedge clk) begin
    if (bscl != pscl || bsda != psda) quiet <= 0;
    else if (quiet < 1000) quiet <= quiet + 1;
    pscl <= bscl;
    psda <= bsda;
  end

  // reference model compared on every settled clock
  always @(negedge clk) begin
    if (!rst && !done && quiet >= 8) begin
      chk(cfg_bytes === exp_flat(), "R4 model cfg_bytes", cfg_bytes, exp_flat());
      chk(freq_sel === exp_freq(), "R9 model freq_sel", 64'(freq_sel), 64'(exp_freq()));
      chk({sw_mode, outputs_hiz, dual_rate_48} === {exp_b[0][3], exp_b[0][0], exp_b[3][6]},
          "R10 model flags", 64'({sw_mode, outputs_hiz, dual_rate_48}),
          64'({exp_b[0][3], exp_b[0][0], exp_b[3][6]}));
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    bsda = 1'b1; wt(H);
    bscl = 1'b1; wt(H);
    bsda = 1'b0; wt(H);
    bscl = 1'b0; wt(6);
  endtask

  task automatic bus_stop();
    bsda = 1'b0; wt(H);
    bscl = 1'b1; wt(H);
    bsda = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      bsda = b[i]; wt(H);
      bscl = 1'b1; wt(H / 2);
      chk(sda_oe === 1'b0, "R5 no drive in data bit", 64'(sda_oe), 64'd0);
      wt(H / 2);
      bscl = 1'b0; wt(6);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input bit commit,
                           input int idx, input string req);
    send_bits(b, 8);
    bsda = 1'b1; wt(H);
    bscl = 1'b1; wt(2);
    if (commit) exp_b[idx] = b;
    wt(6);
    chk(sda_oe === exp_ack, req, 64'(sda_oe), 64'(exp_ack));
    wt(H - 8);
    bscl = 1'b0; wt(6);
  endtask

  task automatic send_frame(input logic [7:0] addr, input logic [7:0] cmd,
                            input logic [7:0] cnt, input logic [63:0] d, input int nd);
    bit ok;
    ok = (addr == 8'hD2);
    bus_start();
    send_byte(addr, ok, 0, 0, ok ? "R2 address ack" : "R2 wrong address no ack");
    send_byte(cmd, ok, 0, 0, "R3 command byte ack");
    send_byte(cnt, ok, 0, 0, "R3 count byte ack");
    for (int k = 0; k < nd; k++)
      send_byte(d[k*8 +: 8], ok, ok, k, "R5 data byte ack");
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_b[k] = 8'h00;
    exp_b[0] = 8'h04; exp_b[1] = 8'h0F; exp_b[2] = 8'hFF;
    exp_b[3] = 8'h3F; exp_b[5] = 8'h33;
    exp_strap = 5'b10110;
    wt(6);
    rst = 1'b0;
    wt(4);
    // R1 reset defaults
    chk(cfg_bytes === 64'h0000_3300_3FFF_0F04, "R1 reset bytes", cfg_bytes, 64'h0000_3300_3FFF_0F04);
    chk(freq_sel === 5'b10110, "R9 hw mode uses straps", 64'(freq_sel), 64'b10110);
    // R8 strap changes after reset ignored
    strap = 5'b01001;
    wt(20);
    chk(freq_sel === 5'b10110, "R8 strap change ignored", 64'(freq_sel), 64'b10110);

    // R2 wrong address: nothing acknowledged, nothing written
    send_frame(8'hD0, 8'h00, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 8);
    bus_stop(); wt(20);
    chk(cfg_bytes === 64'h0000_3300_3FFF_0F04, "R2 wrong address no change", cfg_bytes, 64'h0000_3300_3FFF_0F04);

    // R4 full frame; byte0=0x5A: sw mode, code 01101; byte3=0x40: 48 MHz
    send_frame(8'hD2, 8'hA5, 8'h5A, 64'h1122_3344_4055_665A, 8);
    // R7 ninth data byte not acknowledged
    send_byte(8'h99, 1'b0, 0, 0, "R7 extra byte no ack");
    bus_stop(); wt(20);
    chk(cfg_bytes === 64'h1122_3344_4055_665A, "R4 bytes in order", cfg_bytes, 64'h1122_3344_4055_665A);
    chk(freq_sel === 5'b01101, "R9 sw code mapping", 64'(freq_sel), 64'b01101);
    chk(dual_rate_48 === 1'b1 && sw_mode === 1'b1 && outputs_hiz === 1'b0, "R10 flags after write",
        64'({sw_mode, outputs_hiz, dual_rate_48}), 64'b101);

    // R6 abort after two commits inside a partly shifted third byte
    send_frame(8'hD2, 8'h00, 8'h00, 64'h0000_0000_0000_7701, 2);
    send_bits(8'h00, 4);
    // R11 repeated start begins a new frame at the address byte
    bus_start();
    send_byte(8'hD2, 1'b1, 0, 0, "R11 restart address ack");
    bus_stop(); wt(20);
    chk(cfg_bytes === 64'h1122_3344_4055_7701, "R6 committed bytes kept", cfg_bytes, 64'h1122_3344_4055_7701);
    chk(freq_sel === 5'b10110, "R9 back to hw straps", 64'(freq_sel), 64'b10110);
    chk(outputs_hiz === 1'b1, "R10 hiz request", 64'(outputs_hiz), 64'd1);

    // R3 header values do not land in registers
    send_frame(8'hD2, 8'hFF, 8'hFF, 64'h0, 0);
    bus_stop(); wt(20);
    chk(cfg_bytes === 64'h1122_3344_4055_7701, "R3 header discarded", cfg_bytes, 64'h1122_3344_4055_7701);
    finish_run();
  end
endmodule